// File: doc/BRIEF.md
# Page-mode PSRAM read controller

This block reads 16-bit words from an external asynchronous pseudo-static RAM. The chip has no clock. Every wait the chip needs is counted in cycles of the controller's own clock. A host hands over a start word address and a word count through a valid/ready handshake. The controller then drives the memory's chip enable, output enable, byte-lane enables and address pins. It returns each captured word on a one-cycle valid strobe, in increasing address order.

Reads use page mode. Opening a row, or moving into a new 16-word page, costs the full random-access wait. A word in a page that is already open needs only the short page wait. The chip may hold chip enable low for a limited time only. The controller therefore counts the cycles that chip enable has been low. Before the next word would pass that budget, it raises chip enable, keeps it high for the minimum recovery time, and resumes the same burst with a fresh random access.

All waits come from nanosecond constants and a clock-period parameter: the ceiling of the time over the period, plus one cycle of margin on each capture wait. At the default 4 ns clock the values are as follows. A random access, which also covers the byte-lane, output-enable and read-cycle minimums, is 19 cycles. A page access is 8 cycles, which also covers the 20 ns spacing between page address changes. The chip-enable high time is 2 cycles. The chip-enable low budget is 2000 cycles, which is 8 µs.

Top module: `psram_page_reader`

## Requirements
- R1: During and right after reset, `mem_ce_n`, `mem_oe_n` and every bit of `mem_be_n` are 1, `rd_valid` is 0 and `req_ready` is 1.
- R2: The first word after each falling edge of `mem_ce_n` is presented on `rd_valid` 19 clock cycles after `mem_ce_n` is first seen low.
- R3: A word whose address shares bits [19:4] with the previous word of the same chip-enable period is presented 8 cycles after the previous word.
- R4: A word whose address has bits [3:0] equal to 0 (a page entry) that follows another word with chip enable still low is presented 19 cycles after the previous word.
- R5: `mem_ce_n` is never low for more than 2000 consecutive cycles. A burst that would run past this limit is split by a high period and continues with the next word, so no word is skipped or repeated.
- R6: Every low period of `mem_ce_n` is preceded by at least 2 cycles with `mem_ce_n` high.
- R7: While `mem_ce_n` stays low, `mem_addr` changes only in a cycle where `rd_valid` is 1, and then only to the previous address plus one.
- R8: An accepted request of N words returns exactly N strobes. Word i carries the memory content at start address plus i, taken modulo 2^20. A request with N = 0 returns nothing.
- R9: `req_ready` is 1 only while no burst is in progress. A `req_valid` raised during a burst is not taken and has no effect on the words returned.
- R10: `mem_oe_n` and all bits of `mem_be_n` equal `mem_ce_n` in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers a read request |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 20 | Start word address |
| req_len | input | 16 | Number of words to read |
| rd_valid | output | 1 | One-cycle strobe for a returned word |
| rd_data | output | 16 | Returned word |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_be_n | output | 2 | Memory byte-lane enables, active low |
| mem_addr | output | 20 | Memory word address |
| mem_dq | input | 16 | Memory read data |

## Verification
A capture wait that runs short is visible in the first affected word. The data arrives one strobe early, or it arrives wrong because the memory model returns filler until its access times have passed. If the controller misses a page entry, the strobe spacing is wrong at the word after the boundary. If the chip-enable budget counter drifts, the bench sees either a low period longer than 2000 cycles or a long burst with no break. A wrong remaining-count or address register shows up at the end of the request as a wrong number of strobes, or within one word as wrong data.

// File: rtl/prd_pkg.sv
package prd_pkg;

    // Timing constants of the attached memory, in nanoseconds
    localparam int T_AA_SLOW_NS = 70;   // random access, slow grade
    localparam int T_AA_FAST_NS = 60;   // random access, fast grade
    localparam int T_RC_SLOW_NS = 70;   // minimum random read cycle, slow grade
    localparam int T_RC_FAST_NS = 60;   // minimum random read cycle, fast grade
    localparam int T_LANE_NS    = 70;   // byte-lane enable to data
    localparam int T_PAGE_NS    = 25;   // in-page access
    localparam int T_PSTEP_NS   = 20;   // spacing of page address changes
    localparam int T_OE_NS      = 20;   // output enable to data
    localparam int T_CEHI_NS    = 5;    // chip enable high between cycles
    localparam int T_CELO_NS    = 8000; // longest chip enable low period

    function automatic int ns2cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    typedef enum logic [1:0] {
        ST_IDLE,   // chip enable high, waiting for a request
        ST_OPEN,   // chip enable low, waiting for the next capture
        ST_BREAK,  // budget break: high period, then resume
        ST_CLOSE   // burst done: high period, then idle
    } ctl_state_e;

endpackage

// File: rtl/prd_countdown.sv
module prd_countdown #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == W'(1));

    // R2: a zero wait would never expire and would stall the controller
    assert_load_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

    // R3: after expiry without a reload, the timer is idle
    assert_expire_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> (cnt_q == '0));
endmodule

// File: rtl/prd_lowtime_guard.sv
module prd_lowtime_guard #(
    parameter int LOW_W  = 13,
    parameter int TW     = 5,
    parameter int LIMIT  = 1981,
    parameter int BUDGET = 2000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic [TW-1:0] next_wait,
    output logic          over
);
    localparam logic [LOW_W-1:0] LIMIT_V  = LOW_W'(LIMIT);
    localparam logic [LOW_W-1:0] BUDGET_V = LOW_W'(BUDGET);
    localparam logic [LOW_W-1:0] SAT_V    = {LOW_W{1'b1}};

    logic [LOW_W-1:0] low_d, low_q;
    logic [LOW_W-1:0] projected;

    always_comb begin
        low_d = low_q;
        if (clear)
            low_d = '0;
        else if (run && low_q != SAT_V)
            low_d = low_q + 1'b1;
        // cycles already low, this cycle, and the wait for the next word
        projected = low_q + LOW_W'(1) + LOW_W'(next_wait);
        over      = (projected > LIMIT_V);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) low_q <= '0;
        else        low_q <= low_d;
    end

    assert_budget_R5: assert property (@(posedge clk) disable iff (!rst_n)
        low_q <= BUDGET_V);
endmodule

// File: rtl/prd_addr_step.sv
module prd_addr_step #(
    parameter int ADDR_W    = 20,
    parameter int PAGE_LOG2 = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] nxt,
    output logic              enters_page
);
    assign nxt = addr + 1'b1;

    generate
        if (PAGE_LOG2 == 0) begin : g_nopage
            assign enters_page = 1'b1;
        end else begin : g_page
            assign enters_page = (nxt[PAGE_LOG2-1:0] == '0);
        end
    endgenerate
endmodule

// File: rtl/psram_page_reader.sv
module psram_page_reader
    import prd_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 16,
    parameter int LEN_W      = 16,
    parameter int PAGE_LOG2  = 4,
    parameter int CLK_NS     = 4,
    parameter bit FAST_GRADE = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [LEN_W-1:0]        req_len,
    output logic                    rd_valid,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    mem_ce_n,
    output logic                    mem_oe_n,
    output logic [DATA_W/8-1:0]     mem_be_n,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic [DATA_W-1:0]       mem_dq
);
    localparam int LANES   = DATA_W / 8;
    localparam int AA_NS   = FAST_GRADE ? T_AA_FAST_NS : T_AA_SLOW_NS;
    localparam int RC_NS   = FAST_GRADE ? T_RC_FAST_NS : T_RC_SLOW_NS;
    localparam int RAND_NS = imax(imax(AA_NS, T_LANE_NS), imax(T_OE_NS, RC_NS));
    localparam int AA_WAIT = ns2cyc(RAND_NS, CLK_NS) + 1;
    localparam int PG_WAIT = imax(ns2cyc(T_PAGE_NS, CLK_NS), ns2cyc(T_PSTEP_NS, CLK_NS)) + 1;
    localparam int CPH_CYC = imax(ns2cyc(T_CEHI_NS, CLK_NS), 1);
    localparam int CEM_CYC = T_CELO_NS / CLK_NS;
    localparam int LIMIT   = CEM_CYC - AA_WAIT;
    localparam int TW      = $clog2(imax(imax(AA_WAIT, PG_WAIT), CPH_CYC) + 1);
    localparam int LOW_W   = $clog2(CEM_CYC + AA_WAIT + 2) + 1;

    typedef struct packed {
        ctl_state_e          st;
        logic                ce_n;
        logic [ADDR_W-1:0]   addr;
        logic [LEN_W-1:0]    left;
        logic                vld;
        logic [DATA_W-1:0]   data;
    } ctl_regs_t;

    ctl_regs_t r_d, r_q;

    logic            wt_load, wt_done;
    logic [TW-1:0]   wt_val;
    logic            hd_load, hd_done;
    logic            lt_clear, lt_over;
    logic [TW-1:0]   step_wait;
    logic [ADDR_W-1:0] nxt_addr;
    logic            enters_page;

    prd_addr_step #(.ADDR_W(ADDR_W), .PAGE_LOG2(PAGE_LOG2)) u_step (
        .addr        (r_q.addr),
        .nxt         (nxt_addr),
        .enters_page (enters_page)
    );

    prd_countdown #(.W(TW)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wt_load),
        .load_val (wt_val),
        .done     (wt_done)
    );

    prd_countdown #(.W(TW)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hd_load),
        .load_val (TW'(CPH_CYC)),
        .done     (hd_done)
    );

    prd_lowtime_guard #(.LOW_W(LOW_W), .TW(TW), .LIMIT(LIMIT), .BUDGET(CEM_CYC)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (lt_clear),
        .run       (!r_q.ce_n),
        .next_wait (step_wait),
        .over      (lt_over)
    );

    assign step_wait = enters_page ? TW'(AA_WAIT) : TW'(PG_WAIT);

    always_comb begin
        r_d      = r_q;
        r_d.vld  = 1'b0;
        wt_load  = 1'b0;
        wt_val   = TW'(AA_WAIT);
        hd_load  = 1'b0;
        lt_clear = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid && req_len != '0) begin
                    r_d.st   = ST_OPEN;
                    r_d.ce_n = 1'b0;
                    r_d.addr = req_addr;
                    r_d.left = req_len;
                    wt_load  = 1'b1;
                    lt_clear = 1'b1;
                end
            end
            ST_OPEN: begin
                if (wt_done) begin
                    r_d.vld  = 1'b1;
                    r_d.data = mem_dq;
                    r_d.left = r_q.left - 1'b1;
                    if (r_q.left == LEN_W'(1)) begin
                        r_d.st   = ST_CLOSE;
                        r_d.ce_n = 1'b1;
                        hd_load  = 1'b1;
                    end else begin
                        r_d.addr = nxt_addr;
                        if (lt_over) begin
                            r_d.st   = ST_BREAK;
                            r_d.ce_n = 1'b1;
                            hd_load  = 1'b1;
                        end else begin
                            wt_load = 1'b1;
                            wt_val  = step_wait;
                        end
                    end
                end
            end
            ST_BREAK: begin
                if (hd_done) begin
                    r_d.st   = ST_OPEN;
                    r_d.ce_n = 1'b0;
                    wt_load  = 1'b1;
                    lt_clear = 1'b1;
                end
            end
            ST_CLOSE: begin
                if (hd_done)
                    r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, ce_n: 1'b1, addr: '0, left: '0, vld: 1'b0, data: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign rd_valid  = r_q.vld;
    assign rd_data   = r_q.data;
    assign mem_ce_n  = r_q.ce_n;
    assign mem_oe_n  = r_q.ce_n;
    assign mem_be_n  = {LANES{r_q.ce_n}};
    assign mem_addr  = r_q.addr;

    // R6: a rising chip enable stays high for at least the next cycle
    generate
        if (CPH_CYC >= 2) begin : g_gap_chk
            assert_gap_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(mem_ce_n) |=> mem_ce_n);
        end
    endgenerate

    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n) && (mem_addr != $past(mem_addr))) |-> rd_valid);

    assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_ce_n);

    assert_words_left_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_OPEN) |-> (r_q.left != '0));
endmodule

// File: tb/sim_psram_page_reader.sv
module sim_psram_page_reader;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int LW = 16;
    localparam int AA_C = 19;
    localparam int PG_C = 8;
    localparam int CPH_C = 2;
    localparam int CEM_C = 2000;
    localparam int AA_NEED = 18;
    localparam int PG_NEED = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          req_ready, rd_valid, mem_ce_n, mem_oe_n;
    logic [DW-1:0] rd_data, mem_dq;
    logic [1:0]    mem_be_n;
    logic [AW-1:0] mem_addr;

    psram_page_reader u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
        .mem_addr(mem_addr), .mem_dq(mem_dq)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [15:0] pat(input logic [AW-1:0] a);
        return a[15:0] ^ {a[19:16], a[19:16], a[19:16], a[19:16]} ^ 16'h3C5A;
    endfunction

    // memory model: filler data until its access times have elapsed
    int acc = 0;
    int pg = 0;
    logic prev_ce = 1'b1;
    logic [AW-1:0] prev_a = '0;
    always @(posedge clk) begin
        prev_ce <= mem_ce_n;
        prev_a  <= mem_addr;
        if (mem_ce_n) begin
            acc <= 0; pg <= 0;
        end else if (prev_ce || mem_addr[AW-1:4] != prev_a[AW-1:4]) begin
            acc <= 1; pg <= 1;
        end else if (mem_addr != prev_a) begin
            acc <= acc + 1; pg <= 1;
        end else begin
            acc <= acc + 1; pg <= pg + 1;
        end
    end
    assign mem_dq = (!mem_ce_n && !mem_oe_n && mem_be_n == 2'b00 && acc >= AA_NEED && pg >= PG_NEED)
                    ? pat(mem_addr) : 16'hDEAD;

    // handshake record (posedge), consumed by the negedge monitor
    int hs_cnt = 0;
    logic [AW-1:0] hs_addr = '0;
    always @(posedge clk) if (rst_n && req_valid && req_ready) begin
        hs_cnt  <= hs_cnt + 1;
        hs_addr <= req_addr;
    end

    int cyc = 0, fall_cyc = 0, last_v = 0, low_run = 0, high_run = 100, falls = 0, got = 0, seen = 0;
    bit first_w = 1'b0;
    logic [AW-1:0] exp_a = '0;
    logic pce = 1'b1;
    logic [AW-1:0] pa = '0;
    always @(negedge clk) if (rst_n) begin
        logic [AW-1:0] pnext;
        cyc++;
        pnext = pa + 1'b1;
        if (hs_cnt != seen) begin
            seen  = hs_cnt;
            exp_a = hs_addr;
            got   = 0;
        end
        if (pce && !mem_ce_n) begin
            chk(high_run >= CPH_C, "R6 ce high time", high_run, CPH_C);
            fall_cyc = cyc; first_w = 1'b1; falls++; low_run = 0;
        end
        if (mem_ce_n) begin
            high_run = pce ? high_run + 1 : 1;
        end else begin
            low_run++;
            if (low_run == CEM_C + 1) chk(1'b0, "R5 ce low too long", low_run, CEM_C);
        end
        if (mem_oe_n != mem_ce_n || mem_be_n != {2{mem_ce_n}})
            chk(1'b0, "R10 enables differ from ce", {mem_oe_n, mem_be_n}, {3{mem_ce_n}});
        if (!pce && !mem_ce_n && mem_addr != pa)
            chk(rd_valid && mem_addr == pnext, "R7 address change", mem_addr, pnext);
        if (!mem_ce_n && req_ready)
            chk(1'b0, "R9 ready while busy", req_ready, 0);
        if (rd_valid) begin
            chk(rd_data == pat(exp_a), "R8 data", rd_data, pat(exp_a));
            if (first_w)
                chk(cyc - fall_cyc == AA_C, "R2 first word delay", cyc - fall_cyc, AA_C);
            else if (exp_a[3:0] == 4'd0)
                chk(cyc - last_v == AA_C, "R4 page entry spacing", cyc - last_v, AA_C);
            else
                chk(cyc - last_v == PG_C, "R3 in-page spacing", cyc - last_v, PG_C);
            first_w = 1'b0;
            last_v  = cyc;
            exp_a   = exp_a + 1'b1;
            got++;
        end
        pce = mem_ce_n;
        pa  = mem_addr;
    end

    task automatic send(input logic [AW-1:0] a, input logic [LW-1:0] n);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_len = n;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_req(input int n);
        repeat (2) @(negedge clk);
        while (!req_ready) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(got == n, "R8 word count", got, n);
    endtask

    task automatic run_req(input logic [AW-1:0] a, input logic [LW-1:0] n);
        send(a, n);
        finish_req(int'(n));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1: outputs held inactive during reset
        chk(mem_ce_n == 1'b1 && mem_oe_n == 1'b1 && mem_be_n == 2'b11, "R1 pins in reset",
            {mem_ce_n, mem_oe_n, mem_be_n}, 4'hF);
        chk(rd_valid == 1'b0, "R1 valid in reset", rd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(mem_ce_n == 1'b1, "R1 ce after reset", mem_ce_n, 1);

        // single word (R2), in-page run (R3), page entry (R4), wrap (R8)
        run_req(20'h01230, 16'd1);
        run_req(20'h04560, 16'd9);
        run_req(20'h0ABCE, 16'd20);
        run_req(20'hFFFFD, 16'd6);

        // zero length returns nothing (R8)
        run_req(20'h00777, 16'd0);

        // request raised during a burst is ignored (R9)
        send(20'h22220, 16'd10);
        req_valid = 1'b1; req_addr = 20'h33333; req_len = 16'd5;
        repeat (40) @(negedge clk);
        chk(req_ready == 1'b0, "R9 busy ready", req_ready, 0);
        req_valid = 1'b0;
        finish_req(10);

        // long burst forces a chip-enable break (R5)
        begin
            int f0;
            f0 = falls;
            run_req(20'h12340, 16'd300);
            chk(falls - f0 >= 2, "R5 burst split", falls - f0, 2);
        end

        // random requests
        for (int i = 0; i < 14; i++) begin
            logic [AW-1:0] ra;
            logic [LW-1:0] rn;
            ra = AW'($urandom);
            rn = LW'($urandom % 40);
            run_req(ra, rn);
        end

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule